// File: doc/BRIEF.md
# Access Fault Status Capture Registers

This block keeps the record of the most recent memory-protection fault for the instruction side and the data side of a processor core. A protection checker elsewhere in the core sends it a single-cycle fault event. The event carries the faulting address, the current program counter, a set of cause flags and the mask of protection entries that matched. The block packs this information into status words and stores it next to the faulting addresses. The fault handler then reads the record back over a simple 32-bit register bus.

The same register window also holds the two memory-control words, which software can write, and a fixed base-address word for the on-chip memory. The fault records cannot be written from the bus. Each fault event replaces the previous record. Nothing is accumulated. A data-side fault also refreshes the instruction-side record with the program counter, so the handler can always see which instruction was executing.

Top module: `prot_fault_log`

## Requirements
- R1: A data-side event (`evt_valid`=1, `evt_inst`=0) loads the data fault address with `evt_addr`. It loads the data fault status (offset 0x08) with bit 19 = miss, bit 18 = second address generator, bit 17 = supervisor, bit 16 = write, and bits 15:0 = the hit mask. All other bits are zero.
- R2: A data-side event also loads the instruction fault address (offset 0x18) with `evt_pc`. It loads the instruction fault status (offset 0x14) with the supervisor flag at bit 17 and zero in every other bit.
- R3: An instruction-side event (`evt_inst`=1) loads the instruction fault address with `evt_addr` and the instruction fault status with the R1 layout. The data fault registers are left unchanged.
- R4: Bus writes to the fault status and fault address offsets (0x08, 0x0C, 0x14, 0x18) have no effect and raise no bus error.
- R5: The data memory-control word (offset 0x04) and the instruction memory-control word (offset 0x10) are written by the bus and read back. Both reset to 0x00000001.
- R6: The on-chip memory base word (offset 0x00) reads 0xFF800000 and ignores writes.
- R7: When `evt_nomask`=1 (misalignment, reserved region, or protection disabled), bits 15:0 of the logged status are zero whatever `evt_hitmask` holds.
- R8: All four fault registers reset to zero. A new event overwrites the earlier contents completely, with no OR-ing of old bits.
- R9: A bus access to any offset outside the seven listed above returns zero and pulses `bus_err` high for exactly one cycle. The pulse comes in the cycle after the access.
- R10: Read data appears on `bus_rdata` in the cycle after the read request and reflects the register contents from before any same-cycle event. At all other times `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | Single-cycle fault event strobe |
| evt_inst | input | 1 | 1 = instruction-side fault, 0 = data-side fault |
| evt_write | input | 1 | The faulting access was a write |
| evt_miss | input | 1 | No protection entry matched |
| evt_supv | input | 1 | The core was in supervisor mode |
| evt_dag1 | input | 1 | The access came from the second data address generator |
| evt_nomask | input | 1 | Log a zero hit mask |
| evt_hitmask | input | MASK_W | Matching protection entries |
| evt_addr | input | 32 | Faulting address |
| evt_pc | input | 32 | Current program counter |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset in the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after a read |
| bus_err | output | 1 | Pulse for an unmapped access |

## Verification
Every result of this block is due exactly one clock edge after its stimulus:
- A fault event becomes visible in the registers at the next edge.
- A read returns data, and an unmapped access raises its error, one edge after the request.

The bench keeps a behavioural model that updates on the same edge as the design. It compares `bus_rdata` and `bus_err` on every falling edge, so every output is sampled half a cycle after it is due.

Register contents are observed only through bus reads issued after the stimulus. One read lands in the same cycle as a fault event, to confirm that it returns the pre-event value.

// File: rtl/pfl_pkg.sv
package pfl_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_REGS = 7;

    // Register identifiers; order matches the offset table below.
    typedef enum logic [2:0] {
        RID_BASE  = 3'd0,
        RID_DCTL  = 3'd1,
        RID_DSTAT = 3'd2,
        RID_DADDR = 3'd3,
        RID_ICTL  = 3'd4,
        RID_ISTAT = 3'd5,
        RID_IADDR = 3'd6,
        RID_NONE  = 3'd7
    } reg_id_e;

    localparam logic [7:0] REG_OFS [NUM_REGS] = '{
        8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18
    };

    typedef struct packed {
        logic [DATA_W-1:0] dctl;
        logic [DATA_W-1:0] ictl;
        logic [DATA_W-1:0] dstat;
        logic [DATA_W-1:0] daddr;
        logic [DATA_W-1:0] istat;
        logic [DATA_W-1:0] iaddr;
        logic [DATA_W-1:0] rdata;
        logic              err;
    } state_t;

endpackage

// File: rtl/pfl_bus_decode.sv
module pfl_bus_decode
    import pfl_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_id_e           rid,
    output logic              hit
);

    always_comb begin
        rid = RID_NONE;
        hit = 1'b0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == ADDR_W'(REG_OFS[i])) begin
                rid = reg_id_e'(3'(i));
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/pfl_status_pack.sv
module pfl_status_pack
    import pfl_pkg::*;
#(
    parameter int MASK_W = 16
) (
    input  logic              miss,
    input  logic              dag1,
    input  logic              supv,
    input  logic              wr,
    input  logic              nomask,
    input  logic [MASK_W-1:0] hitmask,
    output logic [DATA_W-1:0] word
);

    localparam int FLAG_W = 4;
    localparam int PAD_W  = DATA_W - MASK_W - FLAG_W;

    logic [MASK_W-1:0] mask_eff;

    always_comb begin
        mask_eff = nomask ? '0 : hitmask;
        word     = {{PAD_W{1'b0}}, miss, dag1, supv, wr, mask_eff};
    end

endmodule

// File: rtl/prot_fault_log.sv
module prot_fault_log
    import pfl_pkg::*;
#(
    parameter int                MASK_W   = 16,
    parameter int                ADDR_W   = 8,
    parameter logic [DATA_W-1:0] BASE_VAL = 32'hFF80_0000,
    parameter logic [DATA_W-1:0] CTL_RST  = 32'h0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic              evt_inst,
    input  logic              evt_write,
    input  logic              evt_miss,
    input  logic              evt_supv,
    input  logic              evt_dag1,
    input  logic              evt_nomask,
    input  logic [MASK_W-1:0] evt_hitmask,
    input  logic [31:0]       evt_addr,
    input  logic [31:0]       evt_pc,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err
);

    state_t            st_d, st_q;
    reg_id_e           rid;
    logic              hit;
    logic [DATA_W-1:0] full_word;
    logic [DATA_W-1:0] supv_word;

    pfl_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .rid  (rid),
        .hit  (hit)
    );

    // Complete status word for the side that faulted.
    pfl_status_pack #(.MASK_W(MASK_W)) u_pack_full (
        .miss    (evt_miss),
        .dag1    (evt_dag1),
        .supv    (evt_supv),
        .wr      (evt_write),
        .nomask  (evt_nomask),
        .hitmask (evt_hitmask),
        .word    (full_word)
    );

    // Supervisor-only word written into the instruction side on a data fault.
    pfl_status_pack #(.MASK_W(MASK_W)) u_pack_supv (
        .miss    (1'b0),
        .dag1    (1'b0),
        .supv    (evt_supv),
        .wr      (1'b0),
        .nomask  (1'b1),
        .hitmask (evt_hitmask),
        .word    (supv_word)
    );

    always_comb begin
        st_d       = st_q;
        st_d.rdata = '0;
        st_d.err   = 1'b0;

        if (bus_sel) begin
            if (!hit) begin
                st_d.err = 1'b1;
            end else if (!bus_wr) begin
                case (rid)
                    RID_BASE:  st_d.rdata = BASE_VAL;
                    RID_DCTL:  st_d.rdata = st_q.dctl;
                    RID_DSTAT: st_d.rdata = st_q.dstat;
                    RID_DADDR: st_d.rdata = st_q.daddr;
                    RID_ICTL:  st_d.rdata = st_q.ictl;
                    RID_ISTAT: st_d.rdata = st_q.istat;
                    RID_IADDR: st_d.rdata = st_q.iaddr;
                    default:   st_d.rdata = '0;
                endcase
            end else begin
                case (rid)
                    RID_DCTL: st_d.dctl = bus_wdata;
                    RID_ICTL: st_d.ictl = bus_wdata;
                    default:  ; // read-only words drop the write
                endcase
            end
        end

        if (evt_valid) begin
            if (evt_inst) begin
                st_d.istat = full_word;
                st_d.iaddr = evt_addr;
            end else begin
                st_d.dstat = full_word;
                st_d.daddr = evt_addr;
                st_d.istat = supv_word;
                st_d.iaddr = evt_pc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.dctl  <= CTL_RST;
            st_q.ictl  <= CTL_RST;
            st_q.dstat <= '0;
            st_q.daddr <= '0;
            st_q.istat <= '0;
            st_q.iaddr <= '0;
            st_q.rdata <= '0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;

endmodule

// File: rtl/prot_fault_log_chk.sv
module prot_fault_log_chk
    import pfl_pkg::*;
#(
    parameter int MASK_W = 16,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic              evt_inst,
    input logic              evt_write,
    input logic              evt_miss,
    input logic              evt_supv,
    input logic              evt_dag1,
    input logic              evt_nomask,
    input logic [MASK_W-1:0] evt_hitmask,
    input logic [31:0]       evt_addr,
    input logic [31:0]       evt_pc,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input state_t            st_q
);

    p_dstat_r1: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_inst |=>
            st_q.daddr == $past(evt_addr) &&
            st_q.dstat == ((32'($past(evt_miss)) << (MASK_W + 3)) |
                           (32'($past(evt_dag1)) << (MASK_W + 2)) |
                           (32'($past(evt_supv)) << (MASK_W + 1)) |
                           (32'($past(evt_write)) << MASK_W) |
                           ($past(evt_nomask) ? 32'd0 : 32'($past(evt_hitmask)))));

    p_ipc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && !evt_inst |=>
            st_q.iaddr == $past(evt_pc) &&
            st_q.istat == (32'($past(evt_supv)) << (MASK_W + 1)));

    p_inst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_inst |=>
            st_q.iaddr == $past(evt_addr) &&
            $stable(st_q.dstat) && $stable(st_q.daddr));

    p_wr_discard_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_valid |=>
            $stable(st_q.dstat) && $stable(st_q.daddr) &&
            $stable(st_q.istat) && $stable(st_q.iaddr));

    p_ctl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(st_q.dctl) && $stable(st_q.ictl));

    p_nomask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid && evt_nomask && !evt_inst |=> st_q.dstat[MASK_W-1:0] == '0);

    p_err_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_rdata == 32'd0);

    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_sel |=> !bus_err && bus_rdata == 32'd0);

    p_wr_nodata_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel && bus_wr |=> bus_rdata == 32'd0);

endmodule

bind prot_fault_log prot_fault_log_chk #(.MASK_W(MASK_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/prot_fault_log_test.sv
module prot_fault_log_test;

    localparam int CLK_PERIOD = 10;
    localparam int MW = 16;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          evt_valid, evt_inst, evt_write, evt_miss, evt_supv, evt_dag1, evt_nomask;
    logic [MW-1:0] evt_hitmask;
    logic [31:0]   evt_addr, evt_pc;
    logic          bus_sel, bus_wr;
    logic [AW-1:0] bus_addr;
    logic [31:0]   bus_wdata;
    logic [31:0]   bus_rdata;
    logic          bus_err;

    int     checks = 0;
    int     errors = 0;
    bit     checking = 0;
    bit     done = 0;
    string  cur_req = "R8";

    // behavioural model
    logic [31:0] m_dctl, m_ictl, m_dstat, m_daddr, m_istat, m_iaddr;
    logic [31:0] exp_rdata;
    logic        exp_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_fault_log #(.MASK_W(MW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .evt_valid(evt_valid), .evt_inst(evt_inst), .evt_write(evt_write),
        .evt_miss(evt_miss), .evt_supv(evt_supv), .evt_dag1(evt_dag1),
        .evt_nomask(evt_nomask), .evt_hitmask(evt_hitmask),
        .evt_addr(evt_addr), .evt_pc(evt_pc),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
    );

    function automatic logic [31:0] status_word(input logic mi, input logic dg,
            input logic sv, input logic wr, input logic nm, input logic [15:0] mk);
        int v;
        v = 0;
        if (mi) v += 'h80000;
        if (dg) v += 'h40000;
        if (sv) v += 'h20000;
        if (wr) v += 'h10000;
        if (!nm) v += int'(mk);
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dctl = 32'h1; m_ictl = 32'h1;
            m_dstat = 0; m_daddr = 0; m_istat = 0; m_iaddr = 0;
            exp_rdata = 0; exp_err = 0;
        end else begin
            exp_rdata = 0; exp_err = 0;
            if (bus_sel) begin
                case (bus_addr)
                    8'h00: if (!bus_wr) exp_rdata = 32'hFF800000;
                    8'h04: if (!bus_wr) exp_rdata = m_dctl; else m_dctl = bus_wdata;
                    8'h08: if (!bus_wr) exp_rdata = m_dstat;
                    8'h0C: if (!bus_wr) exp_rdata = m_daddr;
                    8'h10: if (!bus_wr) exp_rdata = m_ictl; else m_ictl = bus_wdata;
                    8'h14: if (!bus_wr) exp_rdata = m_istat;
                    8'h18: if (!bus_wr) exp_rdata = m_iaddr;
                    default: exp_err = 1;
                endcase
            end
            if (evt_valid) begin
                if (evt_inst) begin
                    m_iaddr = evt_addr;
                    m_istat = status_word(evt_miss, evt_dag1, evt_supv, evt_write, evt_nomask, evt_hitmask);
                end else begin
                    m_daddr = evt_addr;
                    m_dstat = status_word(evt_miss, evt_dag1, evt_supv, evt_write, evt_nomask, evt_hitmask);
                    m_iaddr = evt_pc;
                    m_istat = evt_supv ? 32'h20000 : 32'h0;
                end
            end
        end
    end

    // compare on every clock, half a cycle after the edge
    always @(negedge clk) begin
        if (checking) begin
            checks++;
            if (bus_rdata !== exp_rdata || bus_err !== exp_err) begin
                errors++;
                $display("FAIL %s rdata=%h err=%b expected rdata=%h err=%b",
                         cur_req, bus_rdata, bus_err, exp_rdata, exp_err);
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic read_all();
        for (int i = 0; i < 7; i++) rd(AW'(i * 4));
        @(negedge clk);
    endtask

    task automatic fault(input logic inst, input logic w, input logic mi,
            input logic sv, input logic dg, input logic nm, input logic [15:0] mk,
            input logic [31:0] a, input logic [31:0] pc);
        evt_valid = 1; evt_inst = inst; evt_write = w; evt_miss = mi;
        evt_supv = sv; evt_dag1 = dg; evt_nomask = nm; evt_hitmask = mk;
        evt_addr = a; evt_pc = pc;
        @(negedge clk);
        evt_valid = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0;
        evt_valid = 0; evt_inst = 0; evt_write = 0; evt_miss = 0; evt_supv = 0;
        evt_dag1 = 0; evt_nomask = 0; evt_hitmask = 0; evt_addr = 0; evt_pc = 0;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        @(posedge clk);
        checking = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        cur_req = "R8";  read_all();                       // reset values R5 R6 R8
        cur_req = "R5";  wr(8'h04, 32'hA5A5_0F0F); wr(8'h10, 32'h0000_1234); read_all();
        cur_req = "R6";  wr(8'h00, 32'h1234_5678); rd(8'h00); @(negedge clk);
        cur_req = "R4";  wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 32'hDEAD_BEEF);
                         wr(8'h14, 32'h5555_5555); wr(8'h18, 32'hAAAA_AAAA); read_all();
        cur_req = "R1";  fault(0, 1, 1, 1, 1, 0, 16'h8421, 32'hFFA0_1000, 32'hFFA0_0200); read_all();
        cur_req = "R2";  fault(0, 0, 0, 0, 0, 0, 16'h0003, 32'h0000_0040, 32'h1000_0010); read_all();
        cur_req = "R3";  fault(1, 0, 1, 1, 0, 0, 16'hF0F0, 32'h2000_0008, 32'h3333_3333); read_all();
        cur_req = "R7";  fault(0, 1, 0, 1, 0, 1, 16'hFFFF, 32'h0000_0003, 32'h4444_4440); read_all();
        cur_req = "R7";  fault(1, 0, 0, 0, 1, 1, 16'h1234, 32'h5000_0002, 32'h0); read_all();
        cur_req = "R8";  fault(0, 1, 1, 1, 1, 0, 16'hFFFF, 32'hFFFF_FFFC, 32'hFFFF_FFF0);
                         fault(0, 0, 0, 0, 0, 0, 16'h0001, 32'h0000_0100, 32'h0000_0200); read_all();
        cur_req = "R9";  rd(8'h1C); rd(8'h02); wr(8'hFC, 32'h1); @(negedge clk); @(negedge clk);
        cur_req = "R10"; // read lands in the same cycle as an event: old value expected
        bus_sel = 1; bus_wr = 0; bus_addr = 8'h0C;
        fault(0, 0, 1, 0, 0, 0, 16'h0010, 32'h7777_0000, 32'h8888_0000);
        bus_sel = 0;
        repeat (3) @(negedge clk);
        read_all();
        cur_req = "R4";  // write to a fault register together with an event: event wins
        bus_sel = 1; bus_wr = 1; bus_addr = 8'h08; bus_wdata = 32'hFFFF_FFFF;
        fault(0, 1, 0, 0, 0, 0, 16'h0002, 32'h9999_0000, 32'hAAAA_0000);
        bus_sel = 0; bus_wr = 0;
        read_all();

        done = 1;
        checking = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule